// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller with Byte Lanes

This block is the clocked control path of a small synchronous burst SRAM together with its storage array. On every rising clock edge it samples three chip selects, two address strobes (one meant for a processor, one for a memory controller), a step input, per-lane write enables, a lane-write enable, an all-lanes write and a doze input. From these it picks exactly one action for the cycle: stay idle or deselect, open a read or write burst at the external address, move the burst to its next beat, or hold the burst on its current beat.

The two low address bits form a 2-bit burst counter that wraps after four beats. Beats are visited either in linear order or in XOR order, which is chosen when the burst opens. Read data leaves the array one clock after the address has been registered. The output drive is gated asynchronously by an output enable and is masked while a write is in progress. The data bus is split into an input vector, an output vector and a drive flag. The pad that merges them into a tri-state bus sits outside this block.

Top module: `sync_burst_ram`

## Requirements
- R1: The lane write mask is all ones when `all_wr_n` is low. Otherwise it equals `~lane_wr_n` when `lane_wr_en_n` is low, and zero in all other cases. A cycle is a write only when this mask is non-zero. Lane i covers data bits [8i+7:8i].
- R2: A low `cpu_strobe_n` while `sel_a_n` is low and the chip is selected always opens a read burst at `addr`, whatever the write inputs are.
- R3: A low `ctl_strobe_n` while the chip is selected, and while R2 does not apply, opens a burst at `addr`. The burst is a write when the R1 mask is non-zero and a read otherwise. A write may also follow, as a continuation, the cycle after an R2 read.
- R4: With both strobes high, a burst open and `step_n` low, the access moves to the next beat. The upper address bits hold the burst start. The low two bits are (start + k) mod 4 when `xor_order` was 0 at burst start, and start XOR k when it was 1, where k is the beat count modulo 4. Its direction (read or write) follows R1.
- R5: With both strobes high, a burst open and `step_n` high, the access repeats the current address. Its direction follows R1. With no burst open, both strobes high causes no access.
- R6: The chip is selected only when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. A strobe that would start a burst while the chip is not selected deselects it: the burst ends and no access occurs. A low `cpu_strobe_n` while `sel_a_n` is high is ignored, and the cycle is decided by `ctl_strobe_n` and `step_n` alone.
- R7: A high `doze` overrides every other input. No access occurs, no array word changes, and any open burst ends.
- R8: Data read from an address registered at clock edge t appears on `rd_data` after edge t+1.
- R9: `rd_drive` is high only when read data is being presented and `out_en_n` is low. It follows `out_en_n` without waiting for a clock.
- R10: `rd_drive` is low in the cycle that follows any write edge, even if `out_en_n` is low.
- R11: After reset no burst is open and `rd_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, always read |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| lane_wr_en_n | input | 1 | Enables the per-lane write enables, active low |
| all_wr_n | input | 1 | Writes all lanes, active low |
| doze | input | 1 | Low-power request, active high |
| xor_order | input | 1 | Burst order at burst start: 0 linear, 1 XOR |
| addr | input | ADDR_W | External word address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wr_data | input | LANES*LANE_W | Write data, sampled on the write edge |
| rd_data | output | LANES*LANE_W | Registered read data |
| rd_drive | output | 1 | Bus drive enable for rd_data |

## Verification
Two functions can fall in the same cycle: the read pipeline handing out data fetched on the previous edge, and a new write decision. They collide when a read beat is followed directly by a write continuation or by a controller-strobe write while the output enable stays low. The bench provokes this on purpose and expects the drive to drop for that cycle (R10). It also expects the array to have returned the value held before the write, and later reads must see the new value. A second overlap is a burst step that arrives together with a strobe or with doze. In that case the strobe or doze must win, and the bench judges this against its own model of the address each cycle.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_NEXT = 2'd2,
    SRC_CUR  = 2'd3
  } src_e;

  // low address bits of beat number 'beat' within a burst opened at 'start'
  function automatic logic [1:0] beat_pos(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       xor_mode);
    logic [1:0] sum;
    sum = start + beat;
    beat_pos = xor_mode ? (start ^ beat) : sum;
  endfunction

endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
  import sbr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             step_n,
  input  logic             doze,
  input  logic             burst_live,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             lane_wr_en_n,
  input  logic             all_wr_n,
  output op_e              op_nx,
  output src_e             src_nx,
  output logic [LANES-1:0] lane_we,
  output logic             chip_sel,
  output logic             cpu_take
);

  logic wr_req;

  // R1: lane write mask
  always_comb begin
    lane_we = '0;
    if (!all_wr_n)
      lane_we = '1;
    else if (!lane_wr_en_n)
      lane_we = ~lane_wr_n;
  end

  assign wr_req   = |lane_we;
  assign chip_sel = !sel_a_n && sel_b && !sel_c_n;
  assign cpu_take = !cpu_strobe_n && !sel_a_n;

  // priority: doze, processor strobe, controller strobe, burst step/hold
  always_comb begin
    op_nx  = OP_IDLE;
    src_nx = SRC_NONE;
    if (doze) begin
      op_nx  = OP_IDLE;
      src_nx = SRC_NONE;
    end else if (cpu_take) begin
      if (chip_sel) begin
        op_nx  = OP_READ;
        src_nx = SRC_EXT;
      end
    end else if (!ctl_strobe_n) begin
      if (chip_sel) begin
        op_nx  = wr_req ? OP_WRITE : OP_READ;
        src_nx = SRC_EXT;
      end
    end else if (burst_live) begin
      op_nx  = wr_req ? OP_WRITE : OP_READ;
      src_nx = step_n ? SRC_CUR : SRC_NEXT;
    end
  end

endmodule

// File: rtl/sbr_burst.sv
module sbr_burst
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_e              src,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              xor_order,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] addr_q
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nx;
  logic              mode_q;
  logic [HI_W-1:0]   base_hi;

  assign cnt_nx  = cnt_q + 2'd1;
  assign base_hi = base_q[ADDR_W-1:2];

  always_comb begin
    case (src)
      SRC_EXT:  eff_addr = ext_addr;
      SRC_NEXT: eff_addr = {base_hi, beat_pos(base_q[1:0], cnt_nx, mode_q)};
      default:  eff_addr = {base_hi, beat_pos(base_q[1:0], cnt_q, mode_q)};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      addr_q <= '0;
    end else begin
      case (src)
        SRC_EXT: begin
          base_q <= ext_addr;
          cnt_q  <= 2'd0;
          mode_q <= xor_order;
        end
        SRC_NEXT: cnt_q <= cnt_nx;
        default: ;
      endcase
      if (src != SRC_NONE)
        addr_q <= eff_addr;
    end
  end

  // R4: a step advances the beat counter by one, wrapping
  a_r4_beat_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_NEXT) |=> (cnt_q == $past(cnt_nx)));

  // R4: a step keeps the upper address bits of the burst start
  a_r4_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_NEXT) |=> (addr_q[ADDR_W-1:2] == $past(base_hi)));

  // R5: a hold repeats the registered address
  a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_CUR) |=> $stable(addr_q));

endmodule

// File: rtl/sbr_array.sv
module sbr_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g])
        cells[waddr] <= wdata[g*LANE_W +: LANE_W];
      rd_q <= cells[raddr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sync_burst_ram.sv
module sync_burst_ram
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    step_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    lane_wr_en_n,
  input  logic                    all_wr_n,
  input  logic                    doze,
  input  logic                    xor_order,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);

  localparam int DW = LANES * LANE_W;

  op_e               op_nx;
  op_e               op_q;
  src_e              src_nx;
  logic [LANES-1:0]  lane_we;
  logic [LANES-1:0]  we_eff;
  logic              chip_sel;
  logic              cpu_take;
  logic              burst_live;
  logic              rd_valid_q;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     arr_rdata;

  assign burst_live = (op_q != OP_IDLE);

  sbr_decode #(.LANES(LANES)) u_decode (
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .sel_c_n      (sel_c_n),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .step_n       (step_n),
    .doze         (doze),
    .burst_live   (burst_live),
    .lane_wr_n    (lane_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .all_wr_n     (all_wr_n),
    .op_nx        (op_nx),
    .src_nx       (src_nx),
    .lane_we      (lane_we),
    .chip_sel     (chip_sel),
    .cpu_take     (cpu_take)
  );

  sbr_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src_nx),
    .ext_addr  (addr),
    .xor_order (xor_order),
    .eff_addr  (eff_addr),
    .addr_q    (addr_q)
  );

  assign we_eff = (op_nx == OP_WRITE) ? lane_we : '0;

  sbr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (we_eff),
    .waddr (eff_addr),
    .wdata (wr_data),
    .raddr (addr_q),
    .rdata (arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_IDLE;
      rd_valid_q <= 1'b0;
    end else begin
      op_q       <= op_nx;
      rd_valid_q <= (op_q == OP_READ);
    end
  end

  assign rd_data  = arr_rdata;
  assign rd_drive = rd_valid_q && (op_q != OP_WRITE) && !out_en_n;

  // R2: processor strobe on a selected chip opens a read at the external address
  a_r2_cpu_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && cpu_take && chip_sel) |=> (op_q == OP_READ && addr_q == $past(addr)));

  // R3: controller strobe on a selected chip uses the external address
  a_r3_ctl_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && !cpu_take && !ctl_strobe_n && chip_sel) |=> (addr_q == $past(addr)));

  // R6: a starting strobe on an unselected chip ends the burst
  a_r6_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && (cpu_take || !ctl_strobe_n) && !chip_sel) |=> (op_q == OP_IDLE));

  // R7: doze leaves the block idle
  a_r7_doze_idle: assert property (@(posedge clk) disable iff (!rst_n)
    doze |=> (op_q == OP_IDLE));

  // R8: a registered read address yields valid data one edge later
  a_r8_read_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_READ) |=> rd_valid_q);

  // R10: no bus drive in the cycle after a write edge
  a_r10_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (op_nx == OP_WRITE) |=> !rd_drive);

endmodule

// File: tb/sync_burst_ram_test.sv
module sync_burst_ram_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_a_n, sel_b, sel_c_n;
  logic        cpu_strobe_n, ctl_strobe_n, step_n;
  logic [3:0]  lane_wr_n;
  logic        lane_wr_en_n, all_wr_n, doze, xor_order;
  logic [5:0]  addr;
  logic        out_en_n;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        rd_drive;

  always #10 clk = ~clk;

  sync_burst_ram uut (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .step_n(step_n),
    .lane_wr_n(lane_wr_n), .lane_wr_en_n(lane_wr_en_n), .all_wr_n(all_wr_n),
    .doze(doze), .xor_order(xor_order), .addr(addr), .out_en_n(out_en_n),
    .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string tag = "R11";

  // behavioural reference state
  logic [31:0] m_mem [64];
  int          m_op = 0;      // 0 none, 1 read, 2 write
  int          m_base = 0, m_cnt = 0, m_mode = 0, m_addr = 0;
  bit          m_rdv = 1'b0;
  logic [31:0] m_rdata = '0;

  function automatic int order_pos(int start, int beat, int mode);
    if (mode != 0) return start ^ beat;
    return (start + beat) % 4;
  endfunction

  function automatic logic [31:0] pattern(int a, int salt);
    return 32'h5A11C300 ^ (a * 32'h01030507) ^ (salt * 32'h10204081);
  endfunction

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic model_edge();
    int  mask, kind, op_new, a;
    bit  selected, nrdv;
    logic [31:0] nrd;
    if (!rst_n) begin
      m_op = 0; m_rdv = 0; m_addr = 0; m_base = 0; m_cnt = 0; m_mode = 0;
      return;
    end
    nrdv = (m_op == 1);
    nrd  = m_mem[m_addr];
    mask = 0;
    if (all_wr_n == 1'b0) mask = 15;
    else if (lane_wr_en_n == 1'b0) mask = int'(~lane_wr_n) & 15;
    selected = (sel_a_n == 1'b0) && (sel_b == 1'b1) && (sel_c_n == 1'b0);
    op_new = 0; kind = 0;
    if (doze) begin
      op_new = 0;
    end else if (cpu_strobe_n == 1'b0 && sel_a_n == 1'b0) begin
      if (selected) begin op_new = 1; kind = 1; end
    end else if (ctl_strobe_n == 1'b0) begin
      if (selected) begin op_new = (mask != 0) ? 2 : 1; kind = 1; end
    end else if (m_op != 0) begin
      op_new = (mask != 0) ? 2 : 1;
      kind = step_n ? 3 : 2;
    end
    a = m_addr;
    if (kind == 1) begin
      a = int'(addr); m_base = a; m_cnt = 0; m_mode = int'(xor_order);
    end else if (kind == 2) begin
      m_cnt = (m_cnt + 1) % 4;
      a = (m_base / 4) * 4 + order_pos(m_base % 4, m_cnt, m_mode);
    end else if (kind == 3) begin
      a = (m_base / 4) * 4 + order_pos(m_base % 4, m_cnt, m_mode);
    end
    if (op_new == 2)
      for (int l = 0; l < 4; l++)
        if (mask[l]) m_mem[a][l*8 +: 8] = wr_data[l*8 +: 8];
    m_addr = a;
    m_op = op_new;
    m_rdv = nrdv;
    m_rdata = nrd;
  endtask

  function automatic bit exp_drive();
    return m_rdv && (m_op != 2) && (out_en_n == 1'b0);
  endfunction

  task automatic compare();
    bit e;
    e = exp_drive();
    chk("drive", {31'd0, rd_drive}, {31'd0, e});
    if (e) chk("data", rd_data, m_rdata);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_inputs();
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    cpu_strobe_n = 1; ctl_strobe_n = 1; step_n = 1;
    lane_wr_n = 4'hF; lane_wr_en_n = 1; all_wr_n = 1;
    doze = 0; out_en_n = 0;
  endtask

  // R9: toggle the output enable between edges and watch the drive follow
  task automatic oe_probe();
    bit e;
    out_en_n = 1; #1;
    chk("drive oe high", {31'd0, rd_drive}, 32'd0);
    out_en_n = 0; #1;
    e = exp_drive();
    chk("drive oe low", {31'd0, rd_drive}, {31'd0, e});
  endtask

  task automatic cpu_read(int a, int xo);
    cpu_strobe_n = 0; addr = 6'(a); xor_order = xo[0];
    all_wr_n = 0;            // R2: must not turn into a write
    tick();
    idle_inputs();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) begin
      step_n = 0; tick();
    end
    step_n = 1;
  endtask

  initial begin
    idle_inputs();
    xor_order = 0; addr = '0; wr_data = '0;
    for (int i = 0; i < 64; i++) m_mem[i] = 'x;
    repeat (3) tick();
    rst_n = 1;
    tag = "R11";
    chk("reset drive", {31'd0, rd_drive}, 32'd0);
    tick();

    // fill the array with controller-strobe writes (R1 all-lanes, R3)
    tag = "R3";
    for (int a = 0; a < 64; a++) begin
      ctl_strobe_n = 0; all_wr_n = 0; addr = 6'(a); wr_data = pattern(a, 0);
      tick();
    end
    idle_inputs(); tick(); tick();

    // R2 + R8: processor read with write inputs asserted, then linear burst
    tag = "R2"; cpu_read(5, 0);
    tag = "R8"; tick(); oe_probe();
    tag = "R4"; steps(5); tick(); tick();

    // R4: XOR order from a mid-block start, wraps past four beats
    tag = "R4"; cpu_read(22, 1); steps(6); tick(); tick();

    // R5: hold on current beat, then step again
    tag = "R5"; cpu_read(40, 0); steps(1);
    for (int i = 0; i < 3; i++) tick();
    steps(2); tick(); tick();

    // R1: lane writes with lane enable, lane enables without it (read)
    tag = "R1";
    ctl_strobe_n = 0; lane_wr_en_n = 0; lane_wr_n = 4'b1010; addr = 6'd9;
    wr_data = 32'hDEADBEEF; tick(); idle_inputs();
    ctl_strobe_n = 0; lane_wr_n = 4'b0000; addr = 6'd9; wr_data = 32'h0;
    tick(); idle_inputs(); tick(); tick();
    cpu_read(9, 0); tick(); tick();

    // R3 + R10: read beat followed by write continuation with output enabled
    tag = "R10"; cpu_read(48, 0);
    step_n = 0; all_wr_n = 0; wr_data = 32'h12345678; tick();
    step_n = 0; lane_wr_en_n = 0; lane_wr_n = 4'b1100; all_wr_n = 1;
    wr_data = 32'hCAFEF00D; tick();
    idle_inputs(); tick(); tick();
    tag = "R3"; cpu_read(48, 0); steps(3); tick(); tick();

    // R6: processor strobe ignored with select A high, burst continues
    tag = "R6"; cpu_read(12, 1);
    sel_a_n = 1; cpu_strobe_n = 0; step_n = 0; addr = 6'd60; tick();
    idle_inputs(); steps(1);
    // deselect via select B low, then step does nothing
    ctl_strobe_n = 0; sel_b = 0; addr = 6'd3; tick(); idle_inputs();
    steps(2); tick();
    // deselect via select C high on processor strobe
    cpu_read(30, 0); sel_c_n = 1; cpu_strobe_n = 0; addr = 6'd31; tick();
    idle_inputs(); steps(1); tick();

    // R7: doze during a write burst; no word changes, burst ends
    tag = "R7"; ctl_strobe_n = 0; all_wr_n = 0; addr = 6'd33; wr_data = 32'hAAAA5555;
    tick(); idle_inputs();
    doze = 1; step_n = 0; all_wr_n = 0; ctl_strobe_n = 0; cpu_strobe_n = 0;
    wr_data = 32'h0BADF00D; addr = 6'd34; tick();
    idle_inputs(); steps(2); tick();
    cpu_read(32, 0); steps(3); tick(); tick();

    // R9: async enable during a burst
    tag = "R9"; cpu_read(1, 0); tick(); oe_probe(); steps(1); oe_probe(); tick();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got hang exp finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule